// File: doc/BRIEF.md
# CAN Transmit Request Controller

This block keeps the control and status bits of every message FIFO in a multi-FIFO CAN controller. It also decides which transmit FIFO hands the next frame to the protocol engine. Software reaches each FIFO's control byte through a single addressed read/write port. The protocol engine reports how each frame ended, and per-FIFO strobes report remote frames received and FIFO resets. The block presents the chosen FIFO index with a send-valid flag to the engine.

A FIFO competes for the bus when it is set up to transmit, its send request is set and its queue is not empty. Of these FIFOs, the one with the largest two-bit priority wins, and a tie goes to the lowest index. The choice stays fixed while the engine sends. A completion, arbitration-loss or bus-error event ends the frame and frees the selection. Software cancels a request by writing 0 over a set request bit. The cancel acts at once on an idle FIFO and at the end of the frame on the FIFO that is sending. Error flags clear when the control byte is read. Remote frames can raise the request with no software action.

Top module: `can_txq_ctrl`

## Requirements
- R1: Control byte layout: [1:0] priority, [2] send request, [3] auto remote reply enable, [4] direction (1 = transmit), [5] aborted, [6] lost arbitration, [7] bus error. Bits 5 to 7 are read-only. A read strobe returns the addressed byte on `reg_rdata` one cycle later. After reset every byte reads 0 and `tx_valid` is 0.
- R2: The direction bit [4] takes a write only while `op_mode` equals 3'b100. In any other mode the bit keeps its value, and priority and auto-reply still update.
- R3: On a FIFO whose direction is already 1, writing 1 to bit [2] sets the send request. On a receive FIFO (direction 0), writes to bit [2] and remote frames leave the request at 0.
- R4: A `remote_rx` strobe on a transmit FIFO with auto-reply 1 sets its send request. With auto-reply 0 the request is unchanged.
- R5: At the first clock edge where the block is idle and some FIFO is eligible (direction 1, request 1, `fifo_not_empty` 1), `tx_idx` takes the eligible FIFO with the highest priority, lowest index on ties, and `tx_valid` rises.
- R6: While `tx_valid` is 1, `tx_idx` holds until a frame-end event (`ev_ok`, `ev_arb_lost` or `ev_bus_err`). `tx_valid` is 0 in the cycle after that event. Events arriving while `tx_valid` is 0 are ignored.
- R7: `ev_ok` clears the aborted flag. With `ev_last` 1 it also clears the send request. With `ev_last` 0 the request stays set and the FIFO is selected again.
- R8: `ev_arb_lost` sets the lost-arbitration flag and `ev_bus_err` sets the bus-error flag of the transmitting FIFO. The request stays set for a retry.
- R9: A read returns the flags as they were before the read and clears lost-arbitration and bus-error.
- R10: Writing 0 over a set request on a FIFO that is not transmitting clears the request at once and sets aborted.
- R11: Writing 0 over the request of the transmitting FIFO keeps the request reading 1 until the frame ends. At an arbitration-loss or bus-error end the request clears and aborted sets. At an `ev_ok` end the request clears and aborted reads 0. The FIFO is not selected again.
- R12: A `fifo_clr` strobe clears the send request, aborted, lost-arbitration and bus-error flags in one cycle. Direction, priority and auto-reply are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Controller operating mode; 3'b100 is configuration |
| reg_sel | input | 4 | FIFO index addressed by the register port |
| reg_wr | input | 1 | Write strobe for the addressed control byte |
| reg_rd | input | 1 | Read strobe for the addressed control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| fifo_clr | input | 16 | Per-FIFO reset strobes |
| fifo_not_empty | input | 16 | Per-FIFO queue occupancy |
| remote_rx | input | 16 | Per-FIFO remote frame received strobes |
| ev_ok | input | 1 | Engine: frame sent successfully |
| ev_last | input | 1 | With ev_ok: it was the last queued message |
| ev_arb_lost | input | 1 | Engine: frame lost arbitration |
| ev_bus_err | input | 1 | Engine: bus error during the frame |
| tx_valid | output | 1 | A FIFO is selected for sending |
| tx_idx | output | 4 | Index of the selected FIFO |

## Verification
The bench uses the default parameters: 16 FIFOs, a 3-bit mode field and 3'b100 as the configuration code. With 16 FIFOs, random setups can place ties at any index up to 15 and draw every priority level. Directed sequences take one FIFO through each way a frame can end, with and without a pending cancel. Each random trial checks two successive selections against a bench pick function.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;
  localparam int PRIO_W = 2;
  localparam int CTL_W  = 8;
  localparam int B_REQ  = PRIO_W;
  localparam int B_AUTO = PRIO_W + 1;
  localparam int B_DIR  = PRIO_W + 2;
  localparam int B_ABT  = PRIO_W + 3;
  localparam int B_ARB  = PRIO_W + 4;
  localparam int B_ERR  = PRIO_W + 5;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic ok;
    logic last;
    logic arb;
    logic err;
  } eng_ev_t;
endpackage

// File: rtl/can_txq_fifo_ctl.sv
module can_txq_fifo_ctl
  import can_txq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ok,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [CTL_W-1:0] wdata,
  input  logic             clr,
  input  logic             remote_rx,
  input  logic             not_empty,
  input  logic             is_active,
  input  eng_ev_t          ev,
  output logic [CTL_W-1:0] ctl,
  output logic             elig,
  output prio_t            prio
);
  logic  dir_q, req_q, auto_q, abt_q, arb_q, err_q, pend_q;
  prio_t prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      req_q  <= 1'b0;
      auto_q <= 1'b0;
      abt_q  <= 1'b0;
      arb_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      prio_q <= '0;
    end else begin
      if (rd_hit) begin
        arb_q <= 1'b0;
        err_q <= 1'b0;
      end
      if (remote_rx && auto_q && dir_q) req_q <= 1'b1;
      if (wr_hit) begin
        prio_q <= wdata[PRIO_W-1:0];
        auto_q <= wdata[B_AUTO];
        if (cfg_ok) dir_q <= wdata[B_DIR];
        if (dir_q) begin
          if (wdata[B_REQ] && !req_q) begin
            req_q <= 1'b1;
          end else if (!wdata[B_REQ] && req_q) begin
            if (is_active) begin
              pend_q <= 1'b1;
            end else begin
              req_q <= 1'b0;
              abt_q <= 1'b1;
            end
          end
        end
      end
      if (is_active) begin
        if (ev.ok) begin
          abt_q  <= 1'b0;
          pend_q <= 1'b0;
          if (ev.last || pend_q) req_q <= 1'b0;
        end else if (ev.arb || ev.err) begin
          if (ev.arb) arb_q <= 1'b1;
          if (ev.err) err_q <= 1'b1;
          if (pend_q) begin
            req_q  <= 1'b0;
            abt_q  <= 1'b1;
            pend_q <= 1'b0;
          end
        end
      end
      if (clr) begin
        req_q  <= 1'b0;
        abt_q  <= 1'b0;
        arb_q  <= 1'b0;
        err_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl                = '0;
    ctl[PRIO_W-1:0]    = prio_q;
    ctl[B_REQ]         = req_q;
    ctl[B_AUTO]        = auto_q;
    ctl[B_DIR]         = dir_q;
    ctl[B_ABT]         = abt_q;
    ctl[B_ARB]         = arb_q;
    ctl[B_ERR]         = err_q;
  end

  assign elig = dir_q && req_q && not_empty && !pend_q;
  assign prio = prio_q;

  // R2: direction is frozen outside configuration mode
  a_r2_dir_locked: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> $stable(dir_q));

  // R3: a receive FIFO never raises its request
  a_r3_rx_no_req: assert property (@(posedge clk) disable iff (rst)
    !dir_q |=> !$rose(req_q));

  // R9: a read clears lost-arbitration unless an event sets it anew
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !(is_active && ev.arb)) |=> !arb_q);

  // R12: a FIFO reset leaves request and aborted low
  a_r12_clr: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!req_q && !abt_q && !err_q));
endmodule

// File: rtl/can_txq_arbiter.sv
module can_txq_arbiter
  import can_txq_pkg::*;
#(
  parameter int NUM_FIFO = 16,
  parameter int IDX_W    = 4
) (
  input  logic [NUM_FIFO-1:0] elig,
  input  prio_t [NUM_FIFO-1:0] prio,
  output logic                any_elig,
  output logic [IDX_W-1:0]    pick
);
  prio_t best_p;

  always_comb begin
    any_elig = 1'b0;
    pick     = '0;
    best_p   = '0;
    for (int i = 0; i < NUM_FIFO; i++) begin
      if (elig[i] && (!any_elig || prio[i] > best_p)) begin
        any_elig = 1'b1;
        pick     = IDX_W'(i);
        best_p   = prio[i];
      end
    end
  end
endmodule

// File: rtl/can_txq_sched.sv
module can_txq_sched #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_elig,
  input  logic [IDX_W-1:0] pick,
  input  logic             frame_end,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cur_idx <= '0;
    end else if (busy) begin
      if (frame_end) busy <= 1'b0;
    end else if (any_elig) begin
      busy    <= 1'b1;
      cur_idx <= pick;
    end
  end

  // R6: selection held until a frame ends
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !frame_end) |=> (busy && $stable(cur_idx)));

  // R6: a frame end releases the selection
  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (busy && frame_end) |=> !busy);
endmodule

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl
  import can_txq_pkg::*;
#(
  parameter int              NUM_FIFO = 16,
  parameter int              MODE_W   = 3,
  parameter logic [MODE_W-1:0] CFG_MODE = 3'b100
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [MODE_W-1:0]                         op_mode,
  input  logic [((NUM_FIFO>1)?$clog2(NUM_FIFO):1)-1:0] reg_sel,
  input  logic                                      reg_wr,
  input  logic                                      reg_rd,
  input  logic [CTL_W-1:0]                          reg_wdata,
  output logic [CTL_W-1:0]                          reg_rdata,
  input  logic [NUM_FIFO-1:0]                       fifo_clr,
  input  logic [NUM_FIFO-1:0]                       fifo_not_empty,
  input  logic [NUM_FIFO-1:0]                       remote_rx,
  input  logic                                      ev_ok,
  input  logic                                      ev_last,
  input  logic                                      ev_arb_lost,
  input  logic                                      ev_bus_err,
  output logic                                      tx_valid,
  output logic [((NUM_FIFO>1)?$clog2(NUM_FIFO):1)-1:0] tx_idx
);
  localparam int IDX_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1;

  logic                 cfg_ok;
  logic                 busy;
  logic [IDX_W-1:0]     cur_idx;
  logic                 frame_end;
  eng_ev_t              ev_g;
  logic [NUM_FIFO-1:0]  elig;
  prio_t [NUM_FIFO-1:0] prio;
  logic [CTL_W-1:0]     ctl [NUM_FIFO];
  logic                 any_elig;
  logic [IDX_W-1:0]     pick;

  assign cfg_ok    = (op_mode == CFG_MODE);
  assign ev_g      = '{ok: ev_ok, last: ev_last, arb: ev_arb_lost, err: ev_bus_err};
  assign frame_end = ev_ok || ev_arb_lost || ev_bus_err;

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    logic act;
    assign act = busy && (cur_idx == IDX_W'(i));
    can_txq_fifo_ctl u_ctl (
      .clk       (clk),
      .rst       (rst),
      .cfg_ok    (cfg_ok),
      .wr_hit    (reg_wr && (reg_sel == IDX_W'(i))),
      .rd_hit    (reg_rd && (reg_sel == IDX_W'(i))),
      .wdata     (reg_wdata),
      .clr       (fifo_clr[i]),
      .remote_rx (remote_rx[i]),
      .not_empty (fifo_not_empty[i]),
      .is_active (act),
      .ev        (ev_g),
      .ctl       (ctl[i]),
      .elig      (elig[i]),
      .prio      (prio[i])
    );
  end

  can_txq_arbiter #(.NUM_FIFO(NUM_FIFO), .IDX_W(IDX_W)) u_arb (
    .elig     (elig),
    .prio     (prio),
    .any_elig (any_elig),
    .pick     (pick)
  );

  can_txq_sched #(.IDX_W(IDX_W)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .any_elig  (any_elig),
    .pick      (pick),
    .frame_end (frame_end),
    .busy      (busy),
    .cur_idx   (cur_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= ctl[reg_sel];
  end

  assign tx_valid = busy;
  assign tx_idx   = cur_idx;

  // R5: a selection only starts from an idle state
  a_r5_start_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(any_elig));
endmodule

// File: tb/sim_can_txq_ctrl.sv
module sim_can_txq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_mode = 3'b000;
  logic [3:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] fifo_clr = '0, fifo_not_empty = '0, remote_rx = '0;
  logic        ev_ok = 1'b0, ev_last = 1'b0, ev_arb_lost = 1'b0, ev_bus_err = 1'b0;
  logic        tx_valid;
  logic [3:0]  tx_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_txq_ctrl u0 (
    .clk(clk), .rst(rst), .op_mode(op_mode), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_clr(fifo_clr), .fifo_not_empty(fifo_not_empty), .remote_rx(remote_rx),
    .ev_ok(ev_ok), .ev_last(ev_last), .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err),
    .tx_valid(tx_valid), .tx_idx(tx_idx)
  );

  // bench model for random trials
  bit   m_dir [16];
  bit   m_req [16];
  bit   m_ne  [16];
  int   m_pri [16];

  function automatic int exp_pick();
    int best = -1;
    for (int i = 0; i < 16; i++)
      if (m_dir[i] && m_req[i] && m_ne[i])
        if (best < 0 || m_pri[i] > m_pri[best]) best = i;
    return best;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk); reg_sel = idx[3:0]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [7:0] d);
    @(negedge clk); reg_sel = idx[3:0]; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse_ev(input logic ok, input logic last, input logic arb, input logic err);
    @(negedge clk); ev_ok = ok; ev_last = last; ev_arb_lost = arb; ev_bus_err = err;
    @(negedge clk); ev_ok = 1'b0; ev_last = 1'b0; ev_arb_lost = 1'b0; ev_bus_err = 1'b0;
  endtask

  task automatic pulse_remote(input int idx);
    @(negedge clk); remote_rx = 16'(1) << idx;
    @(negedge clk); remote_rx = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    check("R1 reset tx_valid", tx_valid, 0);
    rd(3, d); check("R1 reset ctl", d, 8'h00);

    // R2 direction locked outside configuration mode
    op_mode = 3'b000;
    wr(3, 8'h1A); rd(3, d); check("R2 dir ignored", d, 8'h0A);
    op_mode = 3'b100;
    wr(3, 8'h1A); rd(3, d); check("R2 dir written", d, 8'h1A);

    // R3 receive FIFO ignores request and remote
    wr(5, 8'h0C); rd(5, d); check("R3 rx req ignored", d, 8'h08);
    pulse_remote(5); rd(5, d); check("R3 rx remote ignored", d, 8'h08);

    // R4 auto remote reply
    wr(6, 8'h18); wr(7, 8'h10);
    pulse_remote(6); rd(6, d); check("R4 remote sets req", d, 8'h1C);
    pulse_remote(7); rd(7, d); check("R4 remote no auto", d, 8'h10);

    // R12 fifo reset on request
    @(negedge clk); fifo_clr = 16'h0040;
    @(negedge clk); fifo_clr = '0;
    rd(6, d); check("R12 clr req", d, 8'h18);

    // R5 select fifo 3
    wr(3, 8'h1E);
    @(negedge clk); fifo_not_empty = 16'h0008;
    @(negedge clk);
    check("R5 valid", tx_valid, 1); check("R5 idx", tx_idx, 3);
    repeat (3) @(negedge clk);
    check("R6 hold valid", tx_valid, 1); check("R6 hold idx", tx_idx, 3);

    // R8 arbitration loss, R9 read clear
    pulse_ev(0, 0, 1, 0);
    check("R6 release", tx_valid, 0);
    rd(3, d); check("R8 arb flag", d, 8'h5E);
    rd(3, d); check("R9 arb cleared", d, 8'h1E);
    check("R8 retry selected", tx_valid, 1);
    pulse_ev(0, 0, 0, 1);
    rd(3, d); check("R8 err flag", d, 8'h9E);
    // R7 ok not last keeps request and clears errors through read
    pulse_ev(1, 0, 0, 0);
    rd(3, d); check("R7 ok keep req", d, 8'h1E);
    check("R7 reselected", tx_valid, 1); check("R7 reselected idx", tx_idx, 3);

    // R11 abort of active fifo ended by arbitration loss
    wr(3, 8'h1A);
    rd(3, d); check("R11 req pending", d, 8'h1E);
    check("R11 still valid", tx_valid, 1);
    pulse_ev(0, 0, 1, 0);
    rd(3, d); check("R11 abort arb end", d, 8'h7A);
    @(negedge clk); check("R11 not reselected", tx_valid, 0);

    // R11 abort of active fifo ended by ok
    wr(3, 8'h1E);
    @(negedge clk); check("R5 select again", tx_valid, 1);
    wr(3, 8'h1A);
    pulse_ev(1, 0, 0, 0);
    rd(3, d); check("R11 abort ok end", d, 8'h1A);
    check("R11 idle after ok", tx_valid, 0);

    // R7 last message clears request
    wr(3, 8'h1E);
    @(negedge clk); check("R7 select", tx_valid, 1);
    pulse_ev(1, 1, 0, 0);
    rd(3, d); check("R7 last clears req", d, 8'h1A);

    // R6 events while idle ignored
    pulse_ev(0, 0, 1, 1);
    rd(3, d); check("R6 idle event ignored", d, 8'h1A);

    // R10 abort of idle fifo, R12 fifo reset
    @(negedge clk); fifo_not_empty = '0;
    wr(3, 8'h1E); wr(3, 8'h1A);
    rd(3, d); check("R10 immediate abort", d, 8'h3A);
    wr(3, 8'h1E);
    @(negedge clk); fifo_clr = 16'h0008;
    @(negedge clk); fifo_clr = '0;
    rd(3, d); check("R12 clr all", d, 8'h1A);

    // R5 directed tie
    do_reset(); op_mode = 3'b100;
    foreach (m_dir[i]) begin m_dir[i] = 0; m_req[i] = 0; m_ne[i] = 0; m_pri[i] = 0; end
    wr(9, 8'h11); wr(9, 8'h15);
    wr(4, 8'h11); wr(4, 8'h15);
    wr(12, 8'h11); wr(12, 8'h15);
    wr(0, 8'h10); wr(0, 8'h14);
    @(negedge clk); fifo_not_empty = 16'hFFFF;
    @(negedge clk); check("R5 tie lowest index", tx_idx, 4);
    check("R5 tie valid", tx_valid, 1);

    // R5 random trials
    for (int t = 0; t < 30; t++) begin
      int e;
      @(negedge clk); fifo_not_empty = '0;
      do_reset(); op_mode = 3'b100;
      for (int i = 0; i < 16; i++) begin
        m_dir[i] = ($urandom % 4) != 0;
        m_req[i] = ($urandom % 3) != 0;
        m_pri[i] = $urandom % 4;
        m_ne[i]  = ($urandom % 4) != 0;
        wr(i, {3'b000, m_dir[i], 2'b00, 2'(m_pri[i])});
        wr(i, {3'b000, m_dir[i], 1'b0, m_req[i], 2'(m_pri[i])});
        m_req[i] = m_req[i] && m_dir[i];
      end
      @(negedge clk);
      for (int i = 0; i < 16; i++) fifo_not_empty[i] = m_ne[i];
      @(negedge clk);
      e = exp_pick();
      check("R5 random valid", tx_valid, (e >= 0) ? 1 : 0);
      if (e >= 0) begin
        check("R5 random idx", tx_idx, e);
        pulse_ev(1, 1, 0, 0);
        check("R6 random release", tx_valid, 0);
        m_req[e] = 0;
        @(negedge clk);
        e = exp_pick();
        check("R5 random second valid", tx_valid, (e >= 0) ? 1 : 0);
        if (e >= 0) check("R5 random second idx", tx_idx, e);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule